// File: doc/BRIEF.md
# Oversampled Serial Receiver with Tagged Byte Queue

This block recovers asynchronous serial bytes from a single input line and queues them for a consumer. The line is oversampled sixteen times per bit. A programmable divisor sets the oversampling tick, and each frame carries eight data bits. A mode field adds an optional even or odd parity bit, and a select bit chooses one or two stop bits. Every received byte enters an eight-entry queue together with two tags: one for a parity mismatch and one for a bad stop bit. The consumer therefore always sees the error state of the byte it is about to take.

The consumer watches the data-available flag or the interrupt request. It reads the byte and its tags at the head of the queue and pops with a one-cycle read strobe. If a byte arrives while the queue is full, that byte is lost and a sticky overrun flag is raised. A clear strobe drops that flag and also empties the queue. A loopback select feeds an internal transmit line to the receiver in place of the pin. A receive enable parks the frame logic without touching the queued bytes.

Top module: `serial_rx_path`

## Requirements
- R1: One oversampling tick occurs every `divisor`+1 clock cycles, and one bit lasts 16 ticks. Frames sent at that rate are recovered for any divisor value (tested at 0 and 2).
- R2: A frame is a low start bit followed by 8 data bits, least significant first. The start bit is accepted only if the line is still low at its mid-bit sample (tick 7). A shorter low pulse produces no byte.
- R3: Each data, parity and stop bit is the majority of the samples taken at ticks 7, 8 and 9 of the bit. A disturbance confined to one of those samples does not change the bit.
- R4: `parity_mode` 00 means no parity bit, 01 means even parity and 10 means odd parity. Code 11 is handled as no parity. A mismatching parity bit sets the parity tag (bit 9 of the queue entry) of that byte.
- R5: With `two_stop`=0 one stop bit is expected, and with `two_stop`=1 two stop bits are expected. Any stop bit sampled low sets the framing tag of that byte.
- R6: The queue holds 8 entries in arrival order. `rx_data`, `par_err` and `frm_err` always show the entry at the head. A `rd_en` pulse while data is available removes that entry.
- R7: A byte completed while the queue holds 8 entries is discarded, and `overrun` becomes 1. It stays 1 until it is cleared.
- R8: A one-cycle `clr_ovf` pulse clears `overrun` and empties the queue.
- R9: `rx_irq` is 1 exactly when at least one byte is available.
- R10: With `loop_en`=1 the receiver listens to `loop_tx` and ignores `serial_in`. With `loop_en`=0 it listens to `serial_in`.
- R11: While `rx_en`=0 the frame logic stays idle, no byte is received, and the queue keeps its contents.
- R12: After reset the queue is empty, and `rx_avail`, `rx_irq` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable |
| serial_in | input | 1 | Serial line from the pin, idle high |
| loop_en | input | 1 | Selects the internal transmit line as the receiver input |
| loop_tx | input | 1 | Internal transmit line |
| divisor | input | 16 | Tick divisor; tick period is divisor+1 clocks |
| parity_mode | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| two_stop | input | 1 | 1 selects two stop bits |
| rd_en | input | 1 | Pops the head entry |
| clr_ovf | input | 1 | Clears the overrun flag and empties the queue |
| rx_data | output | 8 | Byte at the queue head |
| rx_avail | output | 1 | Queue not empty |
| par_err | output | 1 | Parity tag of the head entry |
| frm_err | output | 1 | Framing tag of the head entry |
| overrun | output | 1 | Sticky overrun flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The assertions check the queue bookkeeping on every cycle. The fill level never exceeds eight. An overrun only rises from a full queue. A clear strobe leaves the queue empty with the flag low. A pop lowers the level by one, and a disabled receiver stays idle and holds the level. Everything that depends on the waveform on the line can only be shown by the bench's scenarios: majority voting, rejection of a false start, parity and stop-bit tagging in each mode, divisor timing, and loopback selection.

// File: rtl/serrx_pkg.sv
package serrx_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP1 = 3'd4,
    ST_STOP2 = 3'd5
  } rx_state_e;

  typedef struct packed {
    logic              perr;
    logic              ferr;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam logic [1:0] PM_EVEN = 2'b01;
  localparam logic [1:0] PM_ODD  = 2'b10;
endpackage

// File: rtl/ser_tick_gen.sv
module ser_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clear || cnt_q == divisor) cnt_d = '0;
    else                           cnt_d = cnt_q + 1'b1;
  end

  assign tick = !clear && (cnt_q == divisor);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ser_frame_fsm.sv
module ser_frame_fsm
  import serrx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       line,
  input  logic       tick,
  input  logic [1:0] parity_mode,
  input  logic       two_stop,
  output logic       push,
  output rx_entry_t  push_entry,
  output rx_state_e  state
);
  localparam int SW = $clog2(OSR);
  localparam int BW = $clog2(DATA_W);
  localparam logic [SW-1:0] MID  = SW'(OSR / 2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OSR - 1);

  rx_state_e         state_q, state_d;
  logic [SW-1:0]     scnt_q, scnt_d;
  logic [BW-1:0]     bitn_q, bitn_d;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [2:0]        votes_q, votes_d;
  logic              perr_q, perr_d, ferr_q, ferr_d;
  logic              maj, par_on, par_exp, in_window;

  assign maj       = (votes_q[0] & votes_q[1]) | (votes_q[0] & votes_q[2]) |
                     (votes_q[1] & votes_q[2]);
  assign par_on    = (parity_mode == PM_EVEN) || (parity_mode == PM_ODD);
  assign par_exp   = (parity_mode == PM_ODD) ? ~^shreg_q : ^shreg_q;
  assign in_window = (scnt_q >= MID) && (scnt_q <= MID + SW'(2));

  always_comb begin
    state_d    = state_q;
    scnt_d     = scnt_q;
    bitn_d     = bitn_q;
    shreg_d    = shreg_q;
    votes_d    = votes_q;
    perr_d     = perr_q;
    ferr_d     = ferr_q;
    push       = 1'b0;
    push_entry = '{perr: perr_q, ferr: ferr_q | ~maj, data: shreg_q};
    if (!enable) begin
      state_d = ST_IDLE;
      scnt_d  = '0;
    end else if (state_q == ST_IDLE) begin
      if (!line) begin
        state_d = ST_START;
        scnt_d  = '0;
        bitn_d  = '0;
        perr_d  = 1'b0;
        ferr_d  = 1'b0;
      end
    end else if (tick) begin
      scnt_d = scnt_q + 1'b1;
      if (in_window) votes_d = {votes_q[1:0], line};
      unique case (state_q)
        ST_START: begin
          if (scnt_q == MID && line) state_d = ST_IDLE;
          else if (scnt_q == LAST)   state_d = ST_DATA;
        end
        ST_DATA: if (scnt_q == LAST) begin
          shreg_d = {maj, shreg_q[DATA_W-1:1]};
          bitn_d  = bitn_q + 1'b1;
          if (bitn_q == BW'(DATA_W - 1)) state_d = par_on ? ST_PAR : ST_STOP1;
        end
        ST_PAR: if (scnt_q == LAST) begin
          perr_d  = (maj != par_exp);
          state_d = ST_STOP1;
        end
        ST_STOP1: if (scnt_q == LAST) begin
          if (two_stop) begin
            ferr_d  = ~maj;
            state_d = ST_STOP2;
          end else begin
            push    = 1'b1;
            state_d = ST_IDLE;
          end
        end
        ST_STOP2: if (scnt_q == LAST) begin
          push    = 1'b1;
          state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  assign state = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      bitn_q  <= '0;
      shreg_q <= '0;
      votes_q <= '1;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      scnt_q  <= scnt_d;
      bitn_q  <= bitn_d;
      shreg_q <= shreg_d;
      votes_q <= votes_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end
endmodule

// File: rtl/ser_tag_fifo.sv
module ser_tag_fifo
  import serrx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  rx_entry_t     push_entry,
  input  logic          pop,
  input  logic          flush,
  output rx_entry_t     head_entry,
  output logic [LW-1:0] level,
  output logic          overrun
);
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          ovf_q, ovf_d;
  logic          full, empty, do_push, do_pop;
  rx_entry_t     slots [DEPTH];

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    rx_entry_t slot_q;
    always_ff @(posedge clk) begin
      if (do_push && wr_q == AW'(i)) slot_q <= push_entry;
    end
    assign slots[i] = slot_q;
  end

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    ovf_d = ovf_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
      ovf_d = 1'b0;
    end else begin
      if (push && full) ovf_d = 1'b1;
      if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      if (do_push && !do_pop)      lvl_d = lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
      ovf_q <= ovf_d;
    end
  end

  assign head_entry = slots[rd_q];
  assign level      = lvl_q;
  assign overrun    = ovf_q;
endmodule

// File: rtl/serial_rx_path.sv
module serial_rx_path
  import serrx_pkg::*;
#(
  parameter int DIV_W      = 16,
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 8,
  localparam int LW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              serial_in,
  input  logic              loop_en,
  input  logic              loop_tx,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        parity_mode,
  input  logic              two_stop,
  input  logic              rd_en,
  input  logic              clr_ovf,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_avail,
  output logic              par_err,
  output logic              frm_err,
  output logic              overrun,
  output logic              rx_irq
);
  logic      line_raw, sync1_q, sync2_q, tick, push_valid;
  rx_entry_t push_entry, head_entry;
  rx_state_e fsm_state;
  logic [LW-1:0] fifo_level;

  assign line_raw = loop_en ? loop_tx : serial_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= line_raw;
      sync2_q <= sync1_q;
    end
  end

  ser_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (fsm_state == ST_IDLE),
    .divisor (divisor),
    .tick    (tick)
  );

  ser_frame_fsm #(.OSR(OSR)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (rx_en),
    .line        (sync2_q),
    .tick        (tick),
    .parity_mode (parity_mode),
    .two_stop    (two_stop),
    .push        (push_valid),
    .push_entry  (push_entry),
    .state       (fsm_state)
  );

  ser_tag_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push_valid),
    .push_entry (push_entry),
    .pop        (rd_en),
    .flush      (clr_ovf),
    .head_entry (head_entry),
    .level      (fifo_level),
    .overrun    (overrun)
  );

  assign rx_avail = (fifo_level != '0);
  assign rx_irq   = rx_avail;
  assign rx_data  = head_entry.data;
  assign par_err  = head_entry.perr;
  assign frm_err  = head_entry.ferr;
endmodule

// File: rtl/serial_rx_path_chk.sv
module serial_rx_path_chk
  import serrx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          rd_en,
  input logic          clr_ovf,
  input logic          rx_avail,
  input logic          overrun,
  input logic          push_valid,
  input logic [LW-1:0] fifo_level,
  input rx_state_e     fsm_state
);
  assert_level_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  assert_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rx_avail && !push_valid && !clr_ovf) |=> fifo_level == $past(fifo_level) - 1'b1);

  assert_ovf_from_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(fifo_level) == LW'(DEPTH));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ovf |=> (!rx_avail && !overrun));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> fsm_state == ST_IDLE);

  assert_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && fsm_state == ST_IDLE && !rd_en && !clr_ovf) |=> $stable(fifo_level));
endmodule

bind serial_rx_path serial_rx_path_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rx_en      (rx_en),
  .rd_en      (rd_en),
  .clr_ovf    (clr_ovf),
  .rx_avail   (rx_avail),
  .overrun    (overrun),
  .push_valid (push_valid),
  .fifo_level (fifo_level),
  .fsm_state  (fsm_state)
);

// File: tb/serial_rx_path_tb.sv
module serial_rx_path_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, rx_en, serial_in, loop_en, loop_tx;
  logic [15:0] divisor;
  logic [1:0]  parity_mode;
  logic        two_stop, rd_en, clr_ovf;
  logic [7:0]  rx_data;
  logic        rx_avail, par_err, frm_err, overrun, rx_irq;

  int n_checks = 0;
  int n_fail   = 0;

  // fields: [12:11] parity mode, [10] two stop, [9] bad parity, [8] bad stop, [7:0] data
  localparam logic [12:0] VEC_TBL [8] = '{
    {2'b00, 1'b0, 1'b0, 1'b0, 8'hA5},
    {2'b01, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'b10, 1'b0, 1'b0, 1'b0, 8'h3C},
    {2'b01, 1'b0, 1'b1, 1'b0, 8'h81},
    {2'b10, 1'b1, 1'b1, 1'b0, 8'h7E},
    {2'b00, 1'b1, 1'b0, 1'b1, 8'hFF},
    {2'b00, 1'b0, 1'b0, 1'b1, 8'h00},
    {2'b11, 1'b0, 1'b1, 1'b0, 8'h5A}
  };

  serial_rx_path u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .serial_in(serial_in),
    .loop_en(loop_en), .loop_tx(loop_tx), .divisor(divisor),
    .parity_mode(parity_mode), .two_stop(two_stop), .rd_en(rd_en),
    .clr_ovf(clr_ovf), .rx_data(rx_data), .rx_avail(rx_avail),
    .par_err(par_err), .frm_err(frm_err), .overrun(overrun), .rx_irq(rx_irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic put_line(input logic v, input bit via_loop);
    if (via_loop) loop_tx = v;
    else          serial_in = v;
  endtask

  task automatic drive_bit(input logic v, input int bt, input bit via_loop, input bit glitch);
    put_line(v, via_loop);
    if (glitch) begin
      repeat (bt / 2) @(negedge clk);
      put_line(~v, via_loop);
      @(negedge clk);
      put_line(v, via_loop);
      repeat (bt / 2 - 1) @(negedge clk);
    end else begin
      repeat (bt) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input logic [1:0] pm, input logic s2,
                            input logic badpar, input logic badstop, input bit via_loop,
                            input int glitch_bit);
    int bt;
    bt = 16 * (int'(divisor) + 1);
    drive_bit(1'b0, bt, via_loop, 1'b0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], bt, via_loop, glitch_bit == i);
    if (pm == 2'b01) drive_bit((^d) ^ badpar, bt, via_loop, 1'b0);
    if (pm == 2'b10) drive_bit((~^d) ^ badpar, bt, via_loop, 1'b0);
    if (s2) drive_bit(1'b1, bt, via_loop, 1'b0);
    drive_bit(~badstop, bt, via_loop, 1'b0);
    put_line(1'b1, via_loop);
    repeat (bt / 2) @(negedge clk);
  endtask

  task automatic pop_one();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_clear();
    clr_ovf = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rx_en = 1'b1; serial_in = 1'b1; loop_en = 1'b0; loop_tx = 1'b1;
    divisor = 16'd0; parity_mode = 2'b00; two_stop = 1'b0; rd_en = 1'b0; clr_ovf = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check(!rx_avail, "R12 avail", rx_avail, 0);
    check(!rx_irq, "R12 irq", rx_irq, 0);
    check(!overrun, "R12 overrun", overrun, 0);

    // vector table: R1 R2 R4 R5 R6 R9
    for (int i = 0; i < 8; i++) begin
      logic [12:0] v;
      logic exp_pe;
      v = VEC_TBL[i];
      divisor = (i % 2 == 1) ? 16'd2 : 16'd0;
      parity_mode = v[12:11];
      two_stop = v[10];
      send_frame(v[7:0], v[12:11], v[10], v[9], v[8], 1'b0, -1);
      exp_pe = v[9] && (v[12:11] == 2'b01 || v[12:11] == 2'b10);
      check(rx_avail, "R1 byte arrived", rx_avail, 1);
      check(rx_irq, "R9 irq with data", rx_irq, 1);
      check(rx_data == v[7:0], "R2 data", rx_data, v[7:0]);
      check(par_err == exp_pe, "R4 parity tag", par_err, exp_pe);
      check(frm_err == v[8], "R5 framing tag", frm_err, v[8]);
      pop_one();
      check(!rx_avail, "R6 empty after pop", rx_avail, 0);
      check(!rx_irq, "R9 irq when empty", rx_irq, 0);
    end
    parity_mode = 2'b00;
    two_stop = 1'b0;

    // R3 one-sample glitch in mid data bit 0 at divisor 2
    divisor = 16'd2;
    send_frame(8'h55, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    check(rx_data == 8'h55, "R3 majority vote", rx_data, 8'h55);
    pop_one();
    divisor = 16'd0;

    // R2 false start rejected
    serial_in = 1'b0;
    repeat (3) @(negedge clk);
    serial_in = 1'b1;
    repeat (64) @(negedge clk);
    check(!rx_avail, "R2 false start", rx_avail, 0);
    send_frame(8'h96, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(rx_data == 8'h96, "R2 after false start", rx_data, 8'h96);
    pop_one();

    // R6 R7 fill, overrun, drain in order
    for (int k = 0; k < 8; k++) send_frame(8'h10 + 8'(k), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(!overrun, "R7 no overrun at 8", overrun, 0);
    send_frame(8'hEE, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(overrun, "R7 overrun set", overrun, 1);
    for (int k = 0; k < 8; k++) begin
      check(rx_data == 8'h10 + 8'(k), "R6 order", rx_data, 8'h10 + k);
      pop_one();
    end
    check(!rx_avail, "R7 ninth byte discarded", rx_avail, 0);
    check(overrun, "R7 overrun sticky", overrun, 1);
    pulse_clear();
    check(!overrun, "R8 overrun cleared", overrun, 0);

    // R8 flush
    for (int k = 0; k < 3; k++) send_frame(8'h20 + 8'(k), 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(rx_avail, "R8 bytes before clear", rx_avail, 1);
    pulse_clear();
    check(!rx_avail, "R8 queue flushed", rx_avail, 0);

    // R11 receiver disabled
    send_frame(8'h42, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    rx_en = 1'b0;
    send_frame(8'h99, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(rx_data == 8'h42, "R11 contents kept", rx_data, 8'h42);
    pop_one();
    check(!rx_avail, "R11 no byte while disabled", rx_avail, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R10 loopback
    loop_en = 1'b1;
    send_frame(8'hC3, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    check(rx_avail && rx_data == 8'hC3, "R10 loopback byte", rx_data, 8'hC3);
    pop_one();
    send_frame(8'h11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(!rx_avail, "R10 pin ignored", rx_avail, 0);
    loop_en = 1'b0;
    repeat (4) @(negedge clk);
    send_frame(8'h3E, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    check(rx_data == 8'h3E, "R10 pin restored", rx_data, 8'h3E);
    pop_one();

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule